// File: doc/BRIEF.md
# Masked packed FP64-to-FP32 converter

This block narrows a vector of IEEE-754 double-precision lanes to single precision. The vector holds two, four or eight 64-bit lanes, and the block converts one lane per active position. Rounding follows a selectable direction, and the block covers overflow, tiny results, NaN quieting and the five floating-point exception conditions. The packed 32-bit result is placed in a 256-bit destination image. The block also receives the previous destination image, so it can keep lanes that it does not write.

Four controls shape how the destination is written. A legacy form writes exactly two lanes and leaves the rest of the destination alone. The non-legacy forms clear every lane above the active length. They also apply a per-lane write mask that either merges (keeps old contents) or zeroes. A memory-source broadcast makes every lane convert element 0. A register-source, full-length form may carry its own rounding direction, which overrides the global one for that operation only.

A spare operand field in the non-legacy encodings must be all ones. Any other value, or the reserved length code, raises an undefined-opcode fault and leaves the destination unchanged. The operation is issued with a one-cycle valid strobe, and its result appears, registered, on the next cycle.

Top module: `f64_to_f32_vcvt`

## Requirements
- R1: `vlen_i` selects the active lane count in non-legacy forms: 00 gives 2, 01 gives 4, 10 gives 8. Code 11 raises `ud_o`.
- R2: With `legacy_i` = 1, lanes 0 and 1 are always converted and `mask_i` is ignored. Lanes 2 to 7 take `prev_i` unchanged, and `xfield_i` is not checked.
- R3: In non-legacy forms, every result lane at or above the active count is zero.
- R4: In non-legacy forms, an active lane whose mask bit is 1 gets the converted value. If its mask bit is 0, the lane becomes zero when `zero_mode_i` = 1 and otherwise takes its `prev_i` lane.
- R5: With `bcast_i` = 1 and `src_mem_i` = 1 in a non-legacy form, every active lane converts source lane 0.
- R6: Rounding codes are 00 nearest-even (ties go to the even value), 01 toward minus infinity, 10 toward plus infinity and 11 toward zero.
- R7: `rc_i` replaces `rm_i` only when the form is non-legacy, the source is a register (`src_mem_i` = 0), `vlen_i` = 10 and `bcast_i` = 1.
- R8: If the rounded magnitude exceeds the largest finite single, the result is infinity or the largest finite single. Nearest-even always gives infinity, toward-zero never does, and a directed mode gives infinity only toward the sign of the value. This raises overflow and inexact.
- R9: A value below the smallest normal single before rounding becomes a rounded subnormal or zero. Underflow is raised only if the result is inexact. A double subnormal input raises denormal.
- R10: A NaN input gives a NaN with the same sign, the quiet bit set and the top 22 payload bits kept. A signalling NaN (payload top bit 0) raises invalid, and infinities and zeros keep their sign.
- R11: The flags are bit 0 invalid, bit 1 denormal, bit 2 overflow, bit 3 underflow and bit 4 inexact. They collect the OR over written lanes only, stay set until `clr_flags_i` is asserted, and read zero on the cycle after a clear.
- R12: In a non-legacy form, a `xfield_i` value other than 11111 raises `ud_o`. In that case the result equals `prev_i` and the flags are not changed.
- R13: Every `op_valid_i` pulse yields exactly one `res_valid_o` pulse one clock later, with the result, the fault and the updated flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Issue strobe for one conversion |
| legacy_i | input | 1 | Legacy two-lane form |
| vlen_i | input | 2 | Vector length code |
| src_mem_i | input | 1 | Source comes from memory (1) or a register (0) |
| bcast_i | input | 1 | Broadcast / embedded-rounding enable |
| zero_mode_i | input | 1 | Masked-off lanes zero (1) or merge (0) |
| mask_i | input | 8 | Per-lane write mask |
| rm_i | input | 2 | Global rounding direction |
| rc_i | input | 2 | Embedded rounding direction |
| xfield_i | input | 5 | Spare operand field, must be all ones |
| src_i | input | 512 | Eight double-precision source lanes, lane 0 in the low bits |
| prev_i | input | 256 | Previous destination, eight single lanes |
| clr_flags_i | input | 1 | Clears the sticky flags |
| res_valid_o | output | 1 | Result strobe |
| res_o | output | 256 | Packed single-precision destination |
| ud_o | output | 1 | Undefined-opcode fault for the strobed result |
| flags_o | output | 5 | Sticky exception flags |

## Verification
The conversion is tried with several kinds of value: exact values, half-ulp ties with even and odd last bits, signed zero, infinity, the largest double, quiet and signalling NaNs with payload, a double subnormal, an exact smallest single subnormal, and an exact value just below the normal range. Each of these is run under all four rounding directions where the direction matters. Ties separate nearest-even from plain rounding up. Negative ties separate the two directed modes. The largest double separates infinity from the clamped finite value, and so shows whether the embedded rounding override was taken. The lane-control patterns use distinctive previous-destination words and uneven masks, so merge, zeroing, upper-lane clearing and legacy retention each leave a different picture. The flags are checked across sequences of clears and operations, so that accumulation, masked-off lanes and faulted operations can be told apart.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;

  localparam int FLAG_W = 5;
  localparam int FL_INV = 0;
  localparam int FL_DEN = 1;
  localparam int FL_OVF = 2;
  localparam int FL_UNF = 3;
  localparam int FL_INX = 4;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_DOWN = 2'b01,
    RND_UP   = 2'b10,
    RND_ZERO = 2'b11
  } rnd_e;

  typedef struct packed {
    logic [31:0]       val;
    logic [FLAG_W-1:0] flags;
  } cvt_res_t;

  // Decide whether the kept magnitude is bumped by one unit in the last place.
  function automatic logic rnd_incr(input logic sgn, input logic lsb,
                                    input logic grd, input logic stk,
                                    input logic [1:0] rm);
    case (rnd_e'(rm))
      RND_NEAR: rnd_incr = grd & (stk | lsb);
      RND_DOWN: rnd_incr = sgn & (grd | stk);
      RND_UP:   rnd_incr = ~sgn & (grd | stk);
      default:  rnd_incr = 1'b0;
    endcase
  endfunction

  // Overflowed result: infinity unless the direction points back toward zero.
  function automatic logic [31:0] ovf_val(input logic sgn, input logic [1:0] rm);
    logic to_inf;
    to_inf = (rnd_e'(rm) == RND_NEAR) || (rnd_e'(rm) == RND_DOWN && sgn) ||
             (rnd_e'(rm) == RND_UP && !sgn);
    ovf_val = to_inf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, 23'h7FFFFF};
  endfunction

  function automatic cvt_res_t f64_to_f32(input logic [63:0] d, input logic [1:0] rm);
    cvt_res_t    r;
    logic        sgn;
    logic [10:0] ex;
    logic [51:0] fr;
    logic [52:0] man;
    logic [79:0] wide;
    logic [79:0] shd;
    logic [23:0] kept;
    logic        grd;
    logic        stk;
    logic        inc;
    logic [24:0] sum;
    int          x32;
    int          shamt;
    int          ef;
    r    = '0;
    sgn  = d[63];
    ex   = d[62:52];
    fr   = d[51:0];
    man  = '0;
    wide = '0;
    shd  = '0;
    kept = '0;
    grd  = 1'b0;
    stk  = 1'b0;
    inc  = 1'b0;
    sum  = '0;
    x32  = 0;
    shamt = 0;
    ef   = 0;
    if (ex == 11'h7FF) begin
      if (fr != '0) begin
        r.val           = {sgn, 8'hFF, 1'b1, fr[50:29]};
        r.flags[FL_INV] = ~fr[51];
      end else begin
        r.val = {sgn, 8'hFF, 23'd0};
      end
    end else if (ex == '0 && fr == '0) begin
      r.val = {sgn, 31'd0};
    end else begin
      r.flags[FL_DEN] = (ex == '0);
      man  = {ex != '0, fr};
      x32  = (ex == '0) ? (1 - 896) : (int'(ex) - 896);
      if (x32 >= 1)            shamt = 0;
      else if (1 - x32 > 26)   shamt = 26;
      else                     shamt = 1 - x32;
      wide = {man, 27'd0};
      shd  = wide >> shamt;
      kept = shd[79:56];
      grd  = shd[55];
      stk  = |shd[54:0];
      inc  = rnd_incr(sgn, kept[0], grd, stk, rm);
      sum  = {1'b0, kept} + {24'd0, inc};
      if (x32 >= 1) begin
        ef = x32 + int'(sum[24]);
        if (ef >= 255) begin
          r.val           = ovf_val(sgn, rm);
          r.flags[FL_OVF] = 1'b1;
          r.flags[FL_INX] = 1'b1;
        end else begin
          r.val           = {sgn, ef[7:0], sum[22:0]};
          r.flags[FL_INX] = grd | stk;
        end
      end else begin
        r.val           = {sgn, 7'd0, sum[23:0]};
        r.flags[FL_INX] = grd | stk;
        r.flags[FL_UNF] = grd | stk;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cvt_lane.sv
module cvt_lane
  import fpcvt_pkg::*;
(
  input  logic [63:0]       d_i,
  input  logic [1:0]        rm_i,
  output logic [31:0]       val_o,
  output logic [FLAG_W-1:0] flags_o
);

  cvt_res_t res;

  assign res     = f64_to_f32(d_i, rm_i);
  assign val_o   = res.val;
  assign flags_o = res.flags;

  logic nan_in;
  assign nan_in = (d_i[62:52] == 11'h7FF) && (d_i[51:0] != '0);

  always_comb begin
    if (nan_in) begin
      AST_NAN_QUIET: assert (val_o[30:22] == 9'h1FF && val_o[31] == d_i[63] && val_o[21:0] == d_i[50:29]); // R10
    end
  end

endmodule

// File: rtl/cvt_flag_acc.sv
module cvt_flag_acc #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] flags_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flags_o <= '0;
    else if (clr_i) flags_o <= set_i;
    else            flags_o <= flags_o | set_i;
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni) !clr_i |=> ((flags_o & $past(flags_o)) == $past(flags_o))); // R11
  AST_FLAGS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni) (clr_i && set_i == '0) |=> flags_o == '0); // R11

endmodule

// File: rtl/f64_to_f32_vcvt.sv
module f64_to_f32_vcvt
  import fpcvt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int DW    = 64,
  parameter int SW    = 32,
  parameter int XF_W  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic                legacy_i,
  input  logic [1:0]          vlen_i,
  input  logic                src_mem_i,
  input  logic                bcast_i,
  input  logic                zero_mode_i,
  input  logic [LANES-1:0]    mask_i,
  input  logic [1:0]          rm_i,
  input  logic [1:0]          rc_i,
  input  logic [XF_W-1:0]     xfield_i,
  input  logic [LANES*DW-1:0] src_i,
  input  logic [LANES*SW-1:0] prev_i,
  input  logic                clr_flags_i,
  output logic                res_valid_o,
  output logic [LANES*SW-1:0] res_o,
  output logic                ud_o,
  output logic [FLAG_W-1:0]   flags_o
);

  localparam int RES_W = LANES * SW;
  localparam int CNT_W = $clog2(LANES + 1);

  // Decoded operation controls, exposed as named wires.
  logic [CNT_W-1:0] act_cnt;
  logic             fault;
  logic             bc_use;
  logic             rc_ovr;
  logic [1:0]       rm_eff;

  always_comb begin
    if (legacy_i)            act_cnt = CNT_W'(2);
    else if (vlen_i == 2'b00) act_cnt = CNT_W'(2);
    else if (vlen_i == 2'b01) act_cnt = CNT_W'(4);
    else                      act_cnt = CNT_W'(LANES);
  end

  assign fault  = !legacy_i && ((xfield_i != '1) || (vlen_i == 2'b11));
  assign bc_use = !legacy_i && bcast_i && src_mem_i;
  assign rc_ovr = !legacy_i && !src_mem_i && bcast_i && (vlen_i == 2'b10);
  assign rm_eff = rc_ovr ? rc_i : rm_i;

  logic [LANES-1:0]  lane_act;
  logic [LANES-1:0]  lane_wr;
  logic [SW-1:0]     cv_l   [LANES];
  logic [FLAG_W-1:0] fl_l   [LANES];
  logic [SW-1:0]     nxt_l  [LANES];

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [DW-1:0] d_sel;
    assign d_sel       = bc_use ? src_i[DW-1:0] : src_i[n*DW +: DW];
    assign lane_act[n] = act_cnt > CNT_W'(n);
    assign lane_wr[n]  = lane_act[n] && (legacy_i || mask_i[n]);

    cvt_lane u_cvt (
      .d_i     (d_sel),
      .rm_i    (rm_eff),
      .val_o   (cv_l[n]),
      .flags_o (fl_l[n])
    );

    assign nxt_l[n] = lane_wr[n]                        ? cv_l[n] :
                      legacy_i                          ? prev_i[n*SW +: SW] :
                      (lane_act[n] && !zero_mode_i)     ? prev_i[n*SW +: SW] :
                                                          '0;
  end

  logic [RES_W-1:0]  nxt_res;
  logic [FLAG_W-1:0] new_fl;
  logic [FLAG_W-1:0] fl_set;

  always_comb begin
    nxt_res = '0;
    new_fl  = '0;
    for (int n = 0; n < LANES; n++) begin
      nxt_res[n*SW +: SW] = nxt_l[n];
      if (lane_wr[n]) new_fl = new_fl | fl_l[n];
    end
  end

  assign fl_set = (op_valid_i && !fault) ? new_fl : '0;

  cvt_flag_acc #(.W(FLAG_W)) u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_flags_i),
    .set_i   (fl_set),
    .flags_o (flags_o)
  );

  logic             leg_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      ud_o        <= 1'b0;
      res_o       <= '0;
      leg_q       <= 1'b0;
      cnt_q       <= '0;
    end else begin
      res_valid_o <= op_valid_i;
      ud_o        <= op_valid_i && fault;
      if (op_valid_i) begin
        res_o <= fault ? prev_i : nxt_res;
        leg_q <= legacy_i;
        cnt_q <= act_cnt;
      end
    end
  end

  // Upper-lane check against the registered length of the last operation.
  logic hi_zero;
  always_comb begin
    hi_zero = 1'b1;
    for (int n = 0; n < LANES; n++) begin
      if (CNT_W'(n) >= cnt_q && res_o[n*SW +: SW] != '0) hi_zero = 1'b0;
    end
  end

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) op_valid_i |=> res_valid_o); // R13
  AST_FAULT_KEEPS_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni) (op_valid_i && fault) |=> (ud_o && res_o == $past(prev_i))); // R12
  AST_LEGACY_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni) (op_valid_i && legacy_i) |=> (res_o[RES_W-1:2*SW] == $past(prev_i[RES_W-1:2*SW]))); // R2
  AST_UPPER_LANES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (res_valid_o && !ud_o && !leg_q) |-> hi_zero); // R3

endmodule

// File: tb/f64_to_f32_vcvt_tb.sv
module f64_to_f32_vcvt_tb;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         legacy = 1'b0;
  logic [1:0]   vlen = 2'b00;
  logic         src_mem = 1'b0;
  logic         bcast = 1'b0;
  logic         zero_mode = 1'b0;
  logic [7:0]   mask = 8'h00;
  logic [1:0]   rm = 2'b00;
  logic [1:0]   rc = 2'b00;
  logic [4:0]   xfield = 5'h1F;
  logic [511:0] src = '0;
  logic [255:0] prev = '0;
  logic         clr = 1'b0;
  logic         res_valid;
  logic [255:0] res;
  logic         ud;
  logic [4:0]   flags;

  f64_to_f32_vcvt u_dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .legacy_i(legacy),
    .vlen_i(vlen), .src_mem_i(src_mem), .bcast_i(bcast), .zero_mode_i(zero_mode),
    .mask_i(mask), .rm_i(rm), .rc_i(rc), .xfield_i(xfield), .src_i(src),
    .prev_i(prev), .clr_flags_i(clr), .res_valid_o(res_valid), .res_o(res),
    .ud_o(ud), .flags_o(flags)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic [63:0] sv [8];
  logic [31:0] ev [8];
  logic [31:0] pv [8];
  logic [4:0]  fl_model = '0;

  logic [255:0] exp_res_q [$];
  logic [4:0]   exp_fl_q  [$];
  logic         exp_ud_q  [$];
  string        tag_q     [$];

  localparam logic [63:0] D_ONE   = 64'h3FF0000000000000;
  localparam logic [63:0] D_M2P5  = 64'hC004000000000000;
  localparam logic [63:0] D_TIE_E = 64'h3FF0000010000000;
  localparam logic [63:0] D_TIE_O = 64'h3FF0000030000000;
  localparam logic [63:0] D_MAX   = 64'h7FEFFFFFFFFFFFFF;
  localparam logic [63:0] D_SNAN  = 64'h7FF4000020000000;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [255:0] act, input logic [255:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic fill_src(input logic [63:0] d);
    for (int n = 0; n < 8; n++) sv[n] = d;
  endtask

  task automatic prev_to_exp();
    for (int n = 0; n < 8; n++) ev[n] = pv[n];
  endtask

  task automatic zero_exp();
    for (int n = 0; n < 8; n++) ev[n] = 32'h0;
  endtask

  // Driver: applies one operation and queues the expected outcome.
  task automatic issue(input logic leg, input logic [1:0] vl, input logic mem,
                       input logic bc, input logic zm, input logic [7:0] mk,
                       input logic [1:0] r, input logic [1:0] c, input logic [4:0] xf,
                       input logic eud, input logic [4:0] efl, input string tag);
    logic [255:0] er;
    @(negedge clk);
    legacy = leg; vlen = vl; src_mem = mem; bcast = bc; zero_mode = zm;
    mask = mk; rm = r; rc = c; xfield = xf;
    for (int n = 0; n < 8; n++) begin
      src[n*64 +: 64] = sv[n];
      prev[n*32 +: 32] = pv[n];
    end
    er = '0;
    for (int n = 0; n < 8; n++) er[n*32 +: 32] = eud ? pv[n] : ev[n];
    if (!eud) fl_model = fl_model | efl;
    exp_res_q.push_back(er);
    exp_fl_q.push_back(fl_model);
    exp_ud_q.push_back(eud);
    tag_q.push_back(tag);
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic clear_flags(input string tag);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    fl_model = '0;
    chk(flags == 5'd0, tag, "flags after clear", {251'd0, flags}, 256'd0);
  endtask

  // Monitor: compares every produced result with the queued expectation.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (exp_res_q.size() == 0) begin
        chk(1'b0, "R13", "unexpected result strobe", res, '0);
      end else begin
        logic [255:0] er;
        logic [4:0]   ef;
        logic         eu;
        string        t;
        er = exp_res_q.pop_front();
        ef = exp_fl_q.pop_front();
        eu = exp_ud_q.pop_front();
        t  = tag_q.pop_front();
        chk(res == er, t, "result", res, er);
        chk(flags == ef, t, "flags", {251'd0, flags}, {251'd0, ef});
        chk(ud == eu, t, "fault", {255'd0, ud}, {255'd0, eu});
      end
    end
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < 8; n++) pv[n] = 32'hA5A5_0000 + 32'(n);
    fill_src(D_ONE);
    zero_exp();
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0 && ud == 1'b0, "R13", "reset strobes", {254'd0, res_valid, ud}, '0);
    chk(res == '0, "R13", "reset result", res, '0);
    chk(flags == '0, "R11", "reset flags", {251'd0, flags}, '0);
    rst_n = 1'b1;

    // R2: legacy keeps lanes 2..7, ignores mask and the spare field.
    sv[0] = D_ONE; sv[1] = D_M2P5;
    prev_to_exp(); ev[0] = 32'h3F800000; ev[1] = 32'hC0200000;
    issue(1, 2'b10, 0, 0, 1, 8'h00, 2'b00, 2'b00, 5'h00, 0, 5'h00, "R2");

    // R6/R3: ties under nearest-even at 256 bits, upper lanes cleared.
    fill_src(D_ONE);
    sv[0] = D_TIE_E; sv[1] = D_TIE_O; sv[2] = 64'h8000000000000000; sv[3] = 64'h7FF0000000000000;
    zero_exp(); ev[0] = 32'h3F800000; ev[1] = 32'h3F800002; ev[2] = 32'h80000000; ev[3] = 32'h7F800000;
    issue(0, 2'b01, 0, 0, 0, 8'hFF, 2'b00, 2'b00, 5'h1F, 0, 5'h10, "R6_R3");
    // R6: toward plus infinity.
    ev[0] = 32'h3F800001; ev[1] = 32'h3F800002;
    issue(0, 2'b01, 0, 0, 0, 8'hFF, 2'b10, 2'b00, 5'h1F, 0, 5'h10, "R6");
    // R6: toward zero.
    ev[0] = 32'h3F800000; ev[1] = 32'h3F800001;
    issue(0, 2'b01, 0, 0, 0, 8'hFF, 2'b11, 2'b00, 5'h1F, 0, 5'h10, "R6");
    // R6: toward minus infinity on a negative and a positive tie.
    sv[0] = 64'hBFF0000010000000; sv[1] = D_TIE_E;
    zero_exp(); ev[0] = 32'hBF800001; ev[1] = 32'h3F800000;
    issue(0, 2'b00, 0, 0, 0, 8'hFF, 2'b01, 2'b00, 5'h1F, 0, 5'h10, "R6");

    clear_flags("R11");

    // R4: merge masking at 512 bits, mask 1010_0101.
    fill_src(D_ONE);
    prev_to_exp();
    for (int n = 0; n < 8; n++) if (8'hA5 & (8'h1 << n)) ev[n] = 32'h3F800000;
    issue(0, 2'b10, 0, 0, 0, 8'hA5, 2'b00, 2'b00, 5'h1F, 0, 5'h00, "R4 merge");
    // R4: zero masking.
    zero_exp();
    for (int n = 0; n < 8; n++) if (8'hA5 & (8'h1 << n)) ev[n] = 32'h3F800000;
    issue(0, 2'b10, 0, 0, 1, 8'hA5, 2'b00, 2'b00, 5'h1F, 0, 5'h00, "R4 zero");

    // R11: a masked-off signalling NaN raises nothing.
    sv[0] = D_ONE; sv[1] = D_SNAN;
    zero_exp(); ev[0] = 32'h3F800000;
    issue(0, 2'b00, 0, 0, 1, 8'h01, 2'b00, 2'b00, 5'h1F, 0, 5'h00, "R11 masked lane");

    // R10/R9: NaN payload, subnormal input, exact subnormal and near-normal results.
    fill_src(D_ONE);
    sv[0] = D_SNAN; sv[1] = 64'h0000000000000001; sv[2] = 64'h36A0000000000000; sv[3] = 64'h3800000000000000;
    zero_exp(); ev[0] = 32'h7FE00001; ev[1] = 32'h00000000; ev[2] = 32'h00000001; ev[3] = 32'h00400000;
    issue(0, 2'b01, 0, 0, 0, 8'hFF, 2'b00, 2'b00, 5'h1F, 0, 5'h1B, "R10_R9");
    // R9: directed rounding of a double subnormal; quiet NaN raises nothing new.
    sv[0] = 64'h0000000000000001; sv[1] = 64'h8000000000000001; sv[2] = 64'hFFF8000000000000;
    zero_exp(); ev[0] = 32'h00000001; ev[1] = 32'h80000000;
    issue(0, 2'b00, 0, 0, 0, 8'hFF, 2'b10, 2'b00, 5'h1F, 0, 5'h1A, "R9");
    sv[0] = 64'hFFF8000000000000; sv[1] = D_ONE;
    zero_exp(); ev[0] = 32'hFFC00000; ev[1] = 32'h3F800000;
    issue(0, 2'b00, 0, 0, 0, 8'hFF, 2'b00, 2'b00, 5'h1F, 0, 5'h00, "R10 quiet");

    // R5: memory broadcast of lane 0; flags stay sticky from before.
    fill_src(D_ONE); sv[0] = D_M2P5;
    zero_exp(); for (int n = 0; n < 4; n++) ev[n] = 32'hC0200000;
    issue(0, 2'b01, 1, 1, 0, 8'hFF, 2'b00, 2'b00, 5'h1F, 0, 5'h00, "R5_R11 sticky");
    // R5: register source ignores broadcast.
    zero_exp(); ev[0] = 32'hC0200000; ev[1] = 32'h3F800000;
    issue(0, 2'b00, 0, 1, 0, 8'hFF, 2'b00, 2'b00, 5'h1F, 0, 5'h00, "R5 register");

    clear_flags("R11");

    // R12: bad spare field faults, keeps the destination and the flags.
    fill_src(D_SNAN);
    issue(0, 2'b10, 0, 0, 0, 8'hFF, 2'b00, 2'b00, 5'h1E, 1, 5'h00, "R12");
    // R1: reserved length code faults.
    issue(0, 2'b11, 0, 0, 0, 8'hFF, 2'b00, 2'b00, 5'h1F, 1, 5'h00, "R1");

    // R7/R8: embedded rounding toward zero clamps to the largest finite value.
    fill_src(D_MAX);
    for (int n = 0; n < 8; n++) ev[n] = 32'h7F7FFFFF;
    issue(0, 2'b10, 0, 1, 0, 8'hFF, 2'b00, 2'b11, 5'h1F, 0, 5'h14, "R7_R8");
    // R7: memory form does not take the override.
    for (int n = 0; n < 8; n++) ev[n] = 32'h7F800000;
    issue(0, 2'b10, 1, 1, 0, 8'hFF, 2'b00, 2'b11, 5'h1F, 0, 5'h14, "R7 memory");
    // R7/R1: 256-bit register form does not take the override.
    zero_exp(); for (int n = 0; n < 4; n++) ev[n] = 32'h7F800000;
    issue(0, 2'b01, 0, 1, 0, 8'hFF, 2'b00, 2'b11, 5'h1F, 0, 5'h14, "R7_R1");
    // R8: negative overflow toward plus infinity clamps to the negative maximum.
    fill_src(64'hFFEFFFFFFFFFFFFF);
    zero_exp(); ev[0] = 32'hFF7FFFFF; ev[1] = 32'hFF7FFFFF;
    issue(0, 2'b00, 0, 0, 0, 8'hFF, 2'b10, 2'b00, 5'h1F, 0, 5'h14, "R8");

    repeat (4) @(negedge clk);
    chk(exp_res_q.size() == 0, "R13", "results outstanding", 256'(exp_res_q.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule